// File: doc/BRIEF.md
# Synthesizer Serial Register Receiver

This block sits on the synthesizer side of a three-wire serial link made of a bit clock, a data line and a load-enable line. A controller shifts in one frame at a time, most significant bit first, and then pulses load enable. The first bit of each frame selects where the payload goes. A high control bit sends the payload to the reference divider. A low control bit sends it to the main loop divider, which is a programmable count N followed by a swallow count A.

All three serial lines are asynchronous to the system clock. The block passes them through a synchronizer and looks for rising edges in the system clock domain. Each rising edge of the serial clock shifts one data bit in and advances a bit counter. A rising edge of load enable checks the frame and then clears the counter. A frame is accepted only when its bit count matches the length that its control bit implies. When a frame is accepted, the divider registers change and a one-cycle update strobe marks the change. Any other frame leaves the registers untouched.

Top module: `synth_serial_rx`

## Requirements
- R1: After synchronous reset the reference value is 12, N is 75, A is 0, and the update strobe is low.
- R2: A frame of exactly 6 bits whose first bit is 1 loads the following 5 bits, MSB first, into the reference value. N and A keep their values.
- R3: A frame of exactly 13 bits whose first bit is 0 loads the next 7 bits, MSB first, into N and the last 5 bits, MSB first, into A. The reference value keeps its value.
- R4: At load enable, a frame whose bit count is neither 6 nor 13 is discarded. All three register outputs keep their values and no strobe is produced.
- R5: A frame whose length does not match its control bit is discarded. This covers 6 bits with a leading 0 and 13 bits with a leading 1.
- R6: The bit counter restarts at every load-enable rising edge. Bits sent before an earlier load enable never count toward the next frame.
- R7: The bit counter saturates instead of wrapping. A frame of more than 15 bits is discarded even if its last 6 bits would form a valid reference frame.
- R8: Each accepted frame produces exactly one strobe pulse, one system clock wide, in the first cycle in which the new register values are visible. Load enable held high for a long time still commits only once. The register outputs never change without a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial bit clock (asynchronous); data is taken on its rising edge |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_le_i | input | 1 | Load enable (asynchronous); its rising edge commits the frame |
| ref_div_o | output | REF_W (5) | Current reference divider value |
| n_div_o | output | N_W (7) | Current programmable counter value N |
| a_div_o | output | A_W (5) | Current swallow counter value A |
| upd_stb_o | output | 1 | One-cycle pulse when the register outputs take new values |

## Verification
Directed frames exercise the following cases, each aimed at a specific fault:

- Asymmetric reference payloads and main payloads, which show a bit-order reversal or a wrong split between N and A.
- Lengths one bit short and one bit long, which show an off-by-one in the length decode.
- Frames whose control bit does not match their length, which show a decoder that checks length alone.
- An aborted partial frame followed by a valid one, and a 22-bit frame ending in a valid-looking reference pattern, which show a counter that is not cleared or that wraps.
- A long load-enable pulse, together with a monitor that requires a strobe for every register change, which shows level-triggered commits or missing strobes.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [1:0] {
        FK_NONE = 2'd0,
        FK_REF  = 2'd1,
        FK_MAIN = 2'd2
    } frame_kind_e;

    // Decide what a captured frame is from its bit count and the control bit
    // found where a frame of each legal length would have placed it.
    function automatic frame_kind_e classify(
        input int unsigned nbits,
        input logic        ctl_at_ref,
        input logic        ctl_at_main,
        input int unsigned ref_len,
        input int unsigned main_len
    );
        if (nbits == ref_len && ctl_at_ref)
            return FK_REF;
        if (nbits == main_len && !ctl_at_main)
            return FK_MAIN;
        return FK_NONE;
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
    parameter int unsigned FRAME_W = 13,
    parameter int unsigned CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_stb,
    input  logic               bit_val,
    input  logic               clear,
    output logic [FRAME_W-1:0] shreg_q,
    output logic [CNT_W-1:0]   cnt_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (clear) begin
            cnt_q   <= '0;
        end else if (bit_stb) begin
            shreg_q <= {shreg_q[FRAME_W-2:0], bit_val};
            if (cnt_q != CNT_MAX)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: a load-enable edge always leaves an empty counter behind
    p_cnt_restart_r6: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt_q == '0));

    // R7: once saturated the counter only leaves the ceiling through a clear
    p_cnt_saturate_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !clear) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/srx_bank.sv
module srx_bank
    import srx_pkg::*;
#(
    parameter int unsigned REF_W   = 5,
    parameter int unsigned N_W     = 7,
    parameter int unsigned A_W     = 5,
    parameter int unsigned CNT_W   = 4,
    parameter int unsigned REF_RST = 12,
    parameter int unsigned N_RST   = 75,
    parameter int unsigned A_RST   = 0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   commit,
    input  logic [N_W+A_W:0]       shreg,
    input  logic [CNT_W-1:0]       cnt,
    output logic [REF_W-1:0]       ref_q,
    output logic [N_W-1:0]         n_q,
    output logic [A_W-1:0]         a_q,
    output logic                   stb_q
);
    localparam int unsigned REF_LEN  = REF_W + 1;
    localparam int unsigned MAIN_LEN = N_W + A_W + 1;

    frame_kind_e kind;

    always_comb begin
        kind = classify(int'(cnt), shreg[REF_LEN-1], shreg[MAIN_LEN-1],
                        REF_LEN, MAIN_LEN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= REF_W'(REF_RST);
            n_q   <= N_W'(N_RST);
            a_q   <= A_W'(A_RST);
            stb_q <= 1'b0;
        end else begin
            stb_q <= 1'b0;
            if (commit) begin
                case (kind)
                    FK_REF: begin
                        ref_q <= shreg[REF_W-1:0];
                        stb_q <= 1'b1;
                    end
                    FK_MAIN: begin
                        n_q   <= shreg[N_W+A_W-1:A_W];
                        a_q   <= shreg[A_W-1:0];
                        stb_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R8: the strobe is never wider than one cycle
    p_stb_single_r8: assert property (@(posedge clk) disable iff (rst)
        stb_q |=> !stb_q);

    // R4: without a strobe the stored values do not move
    p_hold_no_stb_r4: assert property (@(posedge clk) disable iff (rst)
        !stb_q |-> $stable({ref_q, n_q, a_q}));

    // R4: an update only follows a frame of a legal length
    p_len_legal_r4: assert property (@(posedge clk) disable iff (rst)
        stb_q |-> ($past(cnt) == CNT_W'(REF_LEN) || $past(cnt) == CNT_W'(MAIN_LEN)));
endmodule

// File: rtl/synth_serial_rx.sv
module synth_serial_rx
    import srx_pkg::*;
#(
    parameter int unsigned REF_W       = 5,
    parameter int unsigned N_W         = 7,
    parameter int unsigned A_W         = 5,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned REF_RST     = 12,
    parameter int unsigned N_RST       = 75,
    parameter int unsigned A_RST       = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk_i,
    input  logic             ser_dat_i,
    input  logic             ser_le_i,
    output logic [REF_W-1:0] ref_div_o,
    output logic [N_W-1:0]   n_div_o,
    output logic [A_W-1:0]   a_div_o,
    output logic             upd_stb_o
);
    localparam int unsigned FRAME_W = N_W + A_W + 1;
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);

    logic [2:0]         line_s;
    logic [1:0]         prev_q;
    logic               bit_stb;
    logic               le_rise;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;

    srx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({ser_le_i, ser_dat_i, ser_clk_i}),
        .dout (line_s)
    );

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= {line_s[2], line_s[0]};
    end

    assign bit_stb = line_s[0] & ~prev_q[0];
    assign le_rise = line_s[2] & ~prev_q[1];

    srx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .bit_stb (bit_stb),
        .bit_val (line_s[1]),
        .clear   (le_rise),
        .shreg_q (shreg),
        .cnt_q   (cnt)
    );

    srx_bank #(
        .REF_W(REF_W), .N_W(N_W), .A_W(A_W), .CNT_W(CNT_W),
        .REF_RST(REF_RST), .N_RST(N_RST), .A_RST(A_RST)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .commit (le_rise),
        .shreg  (shreg),
        .cnt    (cnt),
        .ref_q  (ref_div_o),
        .n_q    (n_div_o),
        .a_q    (a_div_o),
        .stb_q  (upd_stb_o)
    );

    // R8: a strobe is only ever the result of a load-enable edge one cycle before
    p_stb_after_le_r8: assert property (@(posedge clk) disable iff (rst)
        upd_stb_o |-> $past(le_rise));
endmodule

// File: tb/tb_synth_serial_rx.sv
module tb_synth_serial_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b0;
    logic       sdat = 1'b0;
    logic       sle = 1'b0;
    logic [4:0] ref_div;
    logic [6:0] n_div;
    logic [4:0] a_div;
    logic       upd;

    int checks = 0;
    int errors = 0;
    int stb_cnt = 0;
    int silent_change = 0;
    bit done = 0;

    int exp_ref = 12;
    int exp_n   = 75;
    int exp_a   = 0;

    logic [16:0] prev_regs;

    always #4 clk = ~clk;

    synth_serial_rx dut (
        .clk       (clk),
        .rst       (rst),
        .ser_clk_i (sclk),
        .ser_dat_i (sdat),
        .ser_le_i  (sle),
        .ref_div_o (ref_div),
        .n_div_o   (n_div),
        .a_div_o   (a_div),
        .upd_stb_o (upd)
    );

    // Strobe counting and change-without-strobe monitor (R8)
    always @(negedge clk) begin
        if (!rst) begin
            if (upd) stb_cnt++;
            if ({ref_div, n_div, a_div} != prev_regs && !upd) silent_change++;
        end
        prev_regs = {ref_div, n_div, a_div};
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Shift nbits (MSB first) then pulse load enable for le_len cycles
    task automatic send(input int nbits, input logic [31:0] bits, input int le_len);
        stb_cnt = 0;
        for (int i = nbits - 1; i >= 0; i--) begin
            @(negedge clk);
            sdat = bits[i];
            sclk = 1'b0;
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(4);
        end
        sclk = 1'b0;
        wait_clk(4);
        sle = 1'b1;
        wait_clk(le_len);
        sle = 1'b0;
        wait_clk(8);
    endtask

    task automatic check_regs(input string req, input int strobes);
        check(req, "ref", int'(ref_div), exp_ref);
        check(req, "N", int'(n_div), exp_n);
        check(req, "A", int'(a_div), exp_a);
        check(req, "strobes", stb_cnt, strobes);
    endtask

    task automatic t_reset;
        check("R1", "ref", int'(ref_div), 12);
        check("R1", "N", int'(n_div), 75);
        check("R1", "A", int'(a_div), 0);
        check("R1", "strobe", int'(upd), 0);
    endtask

    task automatic t_ref_load;
        send(6, {26'd0, 1'b1, 5'b10110}, 14);
        exp_ref = 22;
        check_regs("R2", 1);
        send(6, {26'd0, 1'b1, 5'b00001}, 14);
        exp_ref = 1;
        check_regs("R2", 1);
    endtask

    task automatic t_main_load;
        send(13, {19'd0, 1'b0, 7'd83, 5'd19}, 14);
        exp_n = 83; exp_a = 19;
        check_regs("R3", 1);
        send(13, {19'd0, 1'b0, 7'd74, 5'd29}, 14);
        exp_n = 74; exp_a = 29;
        check_regs("R3", 1);
    endtask

    task automatic t_bad_len;
        send(5,  {27'd0, 5'b11111}, 14);
        check_regs("R4", 0);
        send(7,  {25'd0, 1'b1, 6'b011011}, 14);
        check_regs("R4", 0);
        send(12, {20'd0, 1'b0, 7'd5, 4'd3}, 14);
        check_regs("R4", 0);
        send(14, {18'd0, 1'b0, 7'd9, 5'd9, 1'b1}, 14);
        check_regs("R4", 0);
    endtask

    task automatic t_ctl_mismatch;
        send(6,  {26'd0, 1'b0, 5'b00111}, 14);
        check_regs("R5", 0);
        send(13, {19'd0, 1'b1, 7'd100, 5'd7}, 14);
        check_regs("R5", 0);
    endtask

    task automatic t_restart;
        send(4, {28'd0, 4'b1011}, 14);
        check_regs("R6", 0);
        send(6, {26'd0, 1'b1, 5'b01001}, 14);
        exp_ref = 9;
        check_regs("R6", 1);
        send(9, {23'd0, 9'b001100110}, 14);
        check_regs("R6", 0);
        send(13, {19'd0, 1'b0, 7'd78, 5'd4}, 14);
        exp_n = 78; exp_a = 4;
        check_regs("R6", 1);
    endtask

    task automatic t_long;
        // 22 bits: 16 filler bits, then a reference-shaped tail 1_01010
        send(22, {10'd0, 16'hA5C3, 1'b1, 5'b01010}, 14);
        check_regs("R7", 0);
    endtask

    task automatic t_long_le;
        send(6, {26'd0, 1'b1, 5'b11100}, 80);
        exp_ref = 28;
        check_regs("R8", 1);
        check("R8", "change without strobe", silent_change, 0);
    endtask

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);
        t_reset();
        t_ref_load();
        t_main_load();
        t_bad_len();
        t_ctl_mismatch();
        t_restart();
        t_long();
        t_long_le();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule